// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is a free-running up-counter for timing. A power-of-two prescaler divides the bus clock, and the counter advances by one on every prescaler terminal pulse. A control byte gates the timer in three ways. One bit turns the whole timer on or off. A second bit stops it while the chip is in wait mode. A third bit stops it while a debug freeze is requested. A separate field picks the division ratio, from 1 up to 128. Software reads the count at any time over a small register bus. The count can only be loaded when the test-mode input is high.

The prescaler also drives a divide-by-64 strobe for an external pulse accumulator. This strobe comes from the same prescaler stage, so it stops whenever the timer is halted. When the count wraps, the block sets a sticky overflow flag. Software clears the flag by writing 1 to it.

The register bus is plain. A write completes in the cycle in which `reg_wr` is high, and a read is a combinational view of the register selected by `reg_addr`. There is no stream traffic, so no valid/ready handshake and no back-pressure.

Register map (word address on `reg_addr`):
- 0: count, 16 bits. Byte lane 1 is the high byte and lane 0 is the low byte.
- 1: control byte.
  - Bit 7: enable.
  - Bit 6: stop-in-wait.
  - Bit 5: freeze-enable.
  - Bits 4..0: reserved, read as 0.
- 2: prescale select in bits 2..0.
- 3: overflow flag in bit 0.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count, control byte, prescale select and overflow flag are all 0, and `div64_tick` is low.
- R2: With control bit 7 at 0, the count and the prescaler phase do not change.
- R3: With prescale select k, a running timer advances the count by one once every 2^k running cycles. The count goes up from its value and wraps modulo 2^16.
- R4: Control bit 6 at 1 together with `wait_mode` high halts the count and the prescaler. With bit 6 at 0, `wait_mode` has no effect.
- R5: Control bit 5 at 1 together with `freeze_req` high halts the count and the prescaler. With bit 5 at 0, `freeze_req` has no effect.
- R6: `div64_tick` is a one-cycle strobe.
  - It fires once every 64 running cycles, whatever the prescale select is.
  - It never fires while the timer is disabled or halted.
- R7: A write to address 0 leaves the count unchanged unless `test_mode` is 1.
  - In test mode, each enabled byte lane is loaded with its data byte.
  - The load replaces that cycle's increment.
  - The load does not reset the prescaler phase.
- R8: A read of address 0 returns all 16 count bits from the same cycle. A read of the control byte returns 0 in bits 4..0.
- R9: A count wrap from 0xFFFF to 0 sets the overflow flag, which stays set until a write to address 3 with data bit 0 at 1. A wrap in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address for reads and writes |
| reg_be | input | 2 | Byte-lane enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| test_mode | input | 1 | Allows count writes when high |
| wait_mode | input | 1 | Chip wait state indication |
| freeze_req | input | 1 | Debug freeze request |
| div64_tick | output | 1 | Divide-by-64 strobe for a pulse accumulator |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The counting is tried at several prescale ratios. This separates a wrong terminal-pulse decode from a wrong strobe decode, because the divide-by-64 strobe must keep its spacing whatever the ratio. The wait and freeze inputs are applied both with their control bits set and with them clear. This shows whether each qualifier is masked by its own bit alone. Count loads are tried with `test_mode` high and low, with single and double byte lanes, and in the middle of a prescaler period, which exposes a load that resets the phase. A forced load to just below the wrap point, followed by random mixes of writes, halts and ratios, checks the overflow flag's set, hold and clear priority.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic [1:0] {
    ADDR_CNT  = 2'd0,
    ADDR_CTL1 = 2'd1,
    ADDR_CTL2 = 2'd2,
    ADDR_STAT = 2'd3
  } ptmr_addr_e;

  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_SW_BIT  = 6;
  localparam int CTL_FRZ_BIT = 5;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W     = 7,
  parameter int SEL_W     = 3,
  parameter int TICK_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  assign term[0] = 1'b1;
  for (genvar i = 1; i <= PRE_W; i++) begin : g_term
    assign term[i] = &pre_q[i-1:0];
  end

  assign pulse = run && term[sel];
  assign tick  = run && term[TICK_LOG2];
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16,
  localparam int NB   = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [NB-1:0]    wr_lane,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] nxt;
  logic             any_wr;

  assign nxt    = count + 1'b1;
  assign any_wr = |wr_lane;
  assign wrap   = inc && !any_wr && (&count);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count[b*8 +: 8] <= '0;
      else if (wr_lane[b])       count[b*8 +: 8] <= wdata[b*8 +: 8];
      else if (inc && !any_wr)   count[b*8 +: 8] <= nxt[b*8 +: 8];
    end
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl1,
  input  logic             wr_ctl2,
  input  logic             wr_stat,
  input  logic [7:0]       wbyte,
  input  logic             wrap,
  output logic [7:0]       ctl1,
  output logic [SEL_W-1:0] sel,
  output logic             ovf
);
  import ptmr_pkg::*;
  logic [2:0] ctl_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_bits <= '0;
      sel      <= '0;
      ovf      <= 1'b0;
    end else begin
      if (wr_ctl1) ctl_bits <= wbyte[7:5];
      if (wr_ctl2) sel <= wbyte[SEL_W-1:0];
      if (wrap)                      ovf <= 1'b1;
      else if (wr_stat && wbyte[0])  ovf <= 1'b0;
    end
  end

  assign ctl1 = {ctl_bits, 5'b00000};
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 3,
  parameter int TICK_LOG2 = 6,
  localparam int PRE_W    = (1 << SEL_W) - 1,
  localparam int NB       = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [NB-1:0]    reg_be,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             test_mode,
  input  logic             wait_mode,
  input  logic             freeze_req,
  output logic             div64_tick,
  output logic             ovf_flag
);
  import ptmr_pkg::*;

  logic [7:0]       ctl1;
  logic [SEL_W-1:0] sel;
  logic             run;
  logic             pulse;
  logic             wrap;
  logic [CNT_W-1:0] count;
  logic [NB-1:0]    wr_lane;
  logic             wr_lo;

  assign run = ctl1[CTL_EN_BIT]
            && !(ctl1[CTL_SW_BIT]  && wait_mode)
            && !(ctl1[CTL_FRZ_BIT] && freeze_req);

  assign wr_lo   = reg_wr && reg_be[0];
  assign wr_lane = (reg_wr && test_mode && reg_addr == ADDR_CNT) ? reg_be : '0;

  ptmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .TICK_LOG2(TICK_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel),
    .pulse(pulse), .tick(div64_tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(pulse), .wr_lane(wr_lane),
    .wdata(reg_wdata), .count(count), .wrap(wrap)
  );

  ptmr_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ctl1(wr_lo && reg_addr == ADDR_CTL1),
    .wr_ctl2(wr_lo && reg_addr == ADDR_CTL2),
    .wr_stat(wr_lo && reg_addr == ADDR_STAT),
    .wbyte(reg_wdata[7:0]), .wrap(wrap),
    .ctl1(ctl1), .sel(sel), .ovf(ovf_flag)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CNT:  reg_rdata = count;
      ADDR_CTL1: reg_rdata = {{(CNT_W-8){1'b0}}, ctl1};
      ADDR_CTL2: reg_rdata = {{(CNT_W-SEL_W){1'b0}}, sel};
      default:   reg_rdata = {{(CNT_W-1){1'b0}}, ovf_flag};
    endcase
  end
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W = 16,
  parameter int NB    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             pulse,
  input logic [NB-1:0]    wr_lane,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             div64_tick,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [NB-1:0]    reg_be,
  input logic [CNT_W-1:0] reg_wdata
);
  logic clr_req;
  assign clr_req = reg_wr && reg_addr == 2'd3 && reg_be[0] && reg_wdata[0];

  // R2 / R4 / R5: a halted timer with no load keeps its count
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_lane == '0) |=> $stable(count));

  // R6: the strobe needs a running prescaler
  a_r6_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    div64_tick |-> run);

  // R6: the strobe is one cycle wide
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    div64_tick |=> !div64_tick);

  // R7: without a load the count only steps by zero or one
  a_r7_no_load_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane == '0) |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R9: a wrap sets the flag
  a_r9_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && wr_lane == '0 && &count) |=> ovf_flag);

  // R9: the flag holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_req) |=> ovf_flag);
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pulse(pulse), .wr_lane(wr_lane),
  .count(count), .ovf_flag(ovf_flag), .div64_tick(div64_tick),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata)
);

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [1:0]  reg_be = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        test_mode = 1'b0, wait_mode = 1'b0, freeze_req = 1'b0;
  logic        div64_tick, ovf_flag;

  int total = 0;
  int bad = 0;

  logic [6:0]  m_pre = '0;
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_c1 = '0;
  logic [2:0]  m_k = '0;
  logic        m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptmr_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .test_mode(test_mode), .wait_mode(wait_mode), .freeze_req(freeze_req),
    .div64_tick(div64_tick), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_run(input logic wt, input logic fz);
    return m_c1[7] && !(m_c1[6] && wt) && !(m_c1[5] && fz);
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return {8'd0, m_c1};
      2'd2: return {13'd0, m_k};
      default: return {15'd0, m_ovf};
    endcase
  endfunction

  task automatic step(input string tag, input logic wr, input logic [1:0] a,
                      input logic [1:0] be, input logic [15:0] wd,
                      input logic tm, input logic wt, input logic fz);
    logic run, pulse, load, setf;
    logic [6:0] mask;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_be = be; reg_wdata = wd;
    test_mode = tm; wait_mode = wt; freeze_req = fz;
    run   = m_run(wt, fz);
    mask  = 7'((8'd1 << m_k) - 8'd1);
    pulse = run && ((m_pre & mask) == mask);
    load  = wr && a == 2'd0 && tm && be != 2'b00;
    setf  = pulse && !load && m_cnt == 16'hFFFF;
    if (run) m_pre = m_pre + 7'd1;
    if (load) begin
      if (be[0]) m_cnt[7:0]  = wd[7:0];
      if (be[1]) m_cnt[15:8] = wd[15:8];
    end else if (pulse) m_cnt = m_cnt + 16'd1;
    if (setf) m_ovf = 1'b1;
    else if (wr && a == 2'd3 && be[0] && wd[0]) m_ovf = 1'b0;
    if (wr && be[0] && a == 2'd1) m_c1 = {wd[7:5], 5'd0};
    if (wr && be[0] && a == 2'd2) m_k = wd[2:0];
    @(posedge clk);
    #2;
    check(tag, "rdata", reg_rdata, m_read(a));
    check(tag, "ovf_flag", {15'd0, ovf_flag}, {15'd0, m_ovf});
    check(tag, "div64_tick", {15'd0, div64_tick},
          {15'd0, m_run(wt, fz) && m_pre[5:0] == 6'h3F});
  endtask

  task automatic idle(input string tag, input int n, input logic [1:0] a,
                      input logic wt, input logic fz);
    for (int i = 0; i < n; i++) step(tag, 1'b0, a, 2'b00, 16'd0, 1'b0, wt, fz);
  endtask

  task automatic wreg(input string tag, input logic [1:0] a, input logic [15:0] d);
    step(tag, 1'b1, a, 2'b11, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] cnt_before;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    reg_addr = 2'd0; #1; check("R1", "count", reg_rdata, 16'h0000);
    reg_addr = 2'd1; #1; check("R1", "ctl1", reg_rdata, 16'h0000);
    reg_addr = 2'd2; #1; check("R1", "ctl2", reg_rdata, 16'h0000);
    reg_addr = 2'd3; #1; check("R1", "ovf", reg_rdata, 16'h0000);
    check("R1", "tick", {15'd0, div64_tick}, 16'd0);
    rst_n = 1'b1;

    // R8: reserved control bits read 0
    wreg("R8", 2'd1, 16'h001F);
    wreg("R8", 2'd1, 16'h00FF);
    idle("R8", 2, 2'd1, 1'b0, 1'b0);
    // R3: divide by 1, then by 4
    idle("R3", 20, 2'd0, 1'b0, 1'b0);
    wreg("R3", 2'd2, 16'd2);
    idle("R3", 40, 2'd0, 1'b0, 1'b0);
    // R2: disabled freezes
    wreg("R2", 2'd1, 16'h0000);
    cnt_before = m_cnt;
    idle("R2", 30, 2'd0, 1'b0, 1'b0);
    check("R2", "frozen count", reg_rdata, cnt_before);
    // R4: stop-in-wait
    wreg("R4", 2'd1, 16'h00C0);
    idle("R4", 20, 2'd0, 1'b1, 1'b0);
    idle("R4", 20, 2'd0, 1'b0, 1'b0);
    wreg("R4", 2'd1, 16'h0080);
    idle("R4", 20, 2'd0, 1'b1, 1'b0);
    // R5: freeze
    wreg("R5", 2'd1, 16'h00A0);
    idle("R5", 20, 2'd0, 1'b0, 1'b1);
    wreg("R5", 2'd1, 16'h0080);
    idle("R5", 20, 2'd0, 1'b0, 1'b1);
    // R6: tick spacing at two ratios and while halted
    wreg("R6", 2'd2, 16'd3);
    idle("R6", 200, 2'd0, 1'b0, 1'b0);
    wreg("R6", 2'd2, 16'd7);
    idle("R6", 300, 2'd0, 1'b0, 1'b0);
    wreg("R6", 2'd1, 16'h00C0);
    idle("R6", 140, 2'd0, 1'b1, 1'b0);
    // R7: writes in normal mode ignored, test mode loads lanes
    wreg("R7", 2'd1, 16'h0080);
    wreg("R7", 2'd2, 16'd3);
    step("R7", 1'b1, 2'd0, 2'b11, 16'h1234, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 2'd0, 2'b11, 16'hA5C3, 1'b1, 1'b0, 1'b0);
    step("R7", 1'b1, 2'd0, 2'b01, 16'h0077, 1'b1, 1'b0, 1'b0);
    step("R7", 1'b1, 2'd0, 2'b10, 16'h3300, 1'b1, 1'b0, 1'b0);
    idle("R7", 30, 2'd0, 1'b0, 1'b0);
    // R9: wrap, sticky, clear
    wreg("R9", 2'd2, 16'd0);
    step("R9", 1'b1, 2'd0, 2'b11, 16'hFFFE, 1'b1, 1'b0, 1'b0);
    idle("R9", 5, 2'd3, 1'b0, 1'b0);
    check("R9", "flag after wrap", {15'd0, ovf_flag}, 16'd1);
    wreg("R9", 2'd3, 16'd0);
    wreg("R9", 2'd3, 16'd1);
    check("R9", "flag cleared", {15'd0, ovf_flag}, 16'd0);
    step("R9", 1'b1, 2'd0, 2'b11, 16'hFFFF, 1'b1, 1'b0, 1'b0);
    step("R9", 1'b1, 2'd3, 2'b01, 16'd1, 1'b0, 1'b0, 1'b0);
    check("R9", "set wins over clear", {15'd0, ovf_flag}, 16'd1);

    // R3: random mix
    for (int i = 0; i < 4000; i++) begin
      logic wr, tm, wt, fz;
      logic [1:0] a, be;
      logic [15:0] d;
      wr = ($urandom % 4) == 0;
      a  = 2'($urandom);
      be = 2'($urandom);
      d  = 16'($urandom);
      if (a == 2'd1 && ($urandom % 4) != 0) d[7] = 1'b1;
      if (a == 2'd0 && ($urandom % 2) == 0) d = 16'hFFF0 | 16'(d[3:0]);
      tm = ($urandom % 2) == 0;
      wt = ($urandom % 4) == 0;
      fz = ($urandom % 4) == 0;
      step("R3", wr, a, be, d, tm, wt, fz);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule